// File: doc/BRIEF.md
# Byte-Wide SPI Port with Write-Collision and Overrun Flags

This block is a serial peripheral port that moves one byte at a time, most significant bit first. Configuration makes it either the clock source (master) or the clock follower (slave). In master mode a host write to the data register starts a transfer, and the serial clock is generated from the system clock at one of three rates. In slave mode the port shifts on edges of an external clock, and it can optionally be gated by an active-low select input.

The host sees three registers on a simple single-cycle bus. Offset 0 is the data buffer, offset 1 is the configuration and offset 2 is the status. The shift register is hidden behind the data buffer. A received byte moves into the buffer when the eighth bit arrives, so the next byte can start before the host has read the last one. The interrupt output reflects a sticky completion flag. The clock and data outputs each come as a level and a drive enable. An open-drain option makes a pin drive only low and release otherwise.

Top module: `spi_xfer_port`

## Requirements
- R1: Bytes are sent and received most significant bit first, 8 bits per transfer. With data out looped back to data in, the received byte equals the sent byte for every clock option.
- R2: When a transfer completes and the buffer is free, the received byte is written to the buffer and status bit 0 (full) is set. Status bit 3 (done flag) is also set, and the irq output follows it.
- R3: A host read of offset 0 clears the full bit. If the read falls in the same cycle as a completion, the read returns the old byte, the new byte is stored and the full bit stays set.
- R4: A host write to offset 0 while a transfer is in progress is discarded and sets status bit 1 (collision). That bit stays set until the host writes a 1 to status bit 1. Writing a 1 to status bits 2 or 3 clears those bits in the same way.
- R5: A completion while the full bit is set and no buffer read occurs in that cycle leaves the buffer unchanged and sets the sticky status bit 2 (overrun).
- R6: In master mode a write to offset 0 while idle loads the shift register and starts a transfer. The clock makes 16 transitions and then rests at its idle level. Configuration bits [5:4] set the clock period to 4, 16 or 64 system clocks for values 0, 1 and 2; value 3 acts as 2. Status bit 4 reads 1 during the transfer.
- R7: Configuration bit 1 sets the idle clock level (1 = high). After reset the configuration is 0 and the status reads 0.
- R8: Configuration bit 2 makes data change on the leading clock edge instead of the trailing edge. In master mode, configuration bit 3 moves the input sample to the end of the data-out time.
- R9: With configuration bit 0 set (slave), the sck_oe output is 0 and shifting follows sck_in.
- R10: In slave mode with configuration bit 6 set, a high ss_n clears the bit count and releases sdo_oe.
- R11: With configuration bit 7 set, sdo_out and sck_out are 0 whenever their enables are 1, and a high level is expressed by releasing the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Completion interrupt (sticky) |
| sck_in | input | 1 | Serial clock from a remote master |
| sck_out | output | 1 | Serial clock level in master mode |
| sck_oe | output | 1 | Serial clock drive enable |
| sdo_out | output | 1 | Serial data out level |
| sdo_oe | output | 1 | Serial data out drive enable |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select |

## Verification
Two events can fall in the same cycle: the completion that stores a received byte and the host read that empties the buffer. The bench acts as a remote master in slave mode and leaves a byte unread. It then clocks in a second byte and issues the buffer read a swept number of cycles after the final clock edge, so the read moves from before the store, through the same cycle, to after it. In each case the read must return the first byte, and exactly one of two outcomes must follow: full set with the second byte waiting and no overrun, or full clear with the overrun flag set. The sweep must produce both outcomes.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int ST_FULL = 0;
  localparam int ST_COLL = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_DONE = 3;
  localparam int ST_BUSY = 4;
  localparam int ST_W    = 5;

  typedef struct packed {
    logic       open_drain;
    logic       ss_en;
    logic [1:0] div_sel;
    logic       sample_end;
    logic       out_on_lead;
    logic       idle_hi;
    logic       slave;
  } ctrl_t;

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DIV_BASE_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       idle_hi,
  input  logic [1:0] div_sel,
  output logic       edge_o,
  output logic       lead_o,
  output logic       sck_lvl_o
);
  localparam int CNT_W = DIV_BASE_LOG2 + 4;
  localparam int SH_W  = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic [1:0]       sel_eff;
  logic [SH_W-1:0]  shamt;
  logic             lvl;

  always_comb begin
    sel_eff = (div_sel == 2'd3) ? 2'd2 : div_sel;
    shamt   = SH_W'(DIV_BASE_LOG2 - 1 + 2 * int'(sel_eff));
    half_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      lvl <= idle_hi;
    end else if (cnt == half_m1) begin
      cnt <= '0;
      lvl <= ~lvl;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign edge_o    = run && (cnt == half_m1);
  assign lead_o    = (lvl == idle_hi);
  assign sck_lvl_o = lvl;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              edge_i,
  input  logic              lead_i,
  input  logic              out_on_lead,
  input  logic              sample_end,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int K_W   = $clog2(EDGES + 1);

  logic [K_W-1:0]    k, k_next;
  logic [DATA_W-1:0] tx, rx, rx_next;
  logic is_out, last, shift_now, samp_now;

  always_comb begin
    k_next    = k + K_W'(1);
    is_out    = out_on_lead ? lead_i : !lead_i;
    last      = (k_next == K_W'(EDGES));
    shift_now = edge_i && is_out && (k_next != K_W'(1));
    samp_now  = edge_i && (sample_end ? ((is_out && (k_next != K_W'(1))) || last)
                                      : !is_out);
    rx_next   = samp_now ? {rx[DATA_W-2:0], sdi_i} : rx;
  end

  always_ff @(posedge clk) begin
    if (rst)            tx <= '0;
    else if (load)      tx <= load_data;
    else if (shift_now) tx <= {tx[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      k  <= '0;
      rx <= '0;
    end else if (edge_i) begin
      k  <= last ? '0 : k_next;
      rx <= rx_next;
    end
  end

  assign sdo_o    = tx[DATA_W-1];
  assign active_o = (k != '0);
  assign done_o   = edge_i && last;
  assign rx_o     = rx_next;
endmodule

// File: rtl/spi_xfer_port.sv
module spi_xfer_port
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DIV_BASE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  input  logic              sdi,
  input  logic              ss_n
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] buf_q;
  logic              full, coll, ovf, irq_flag, run;
  logic [2:0]        sck_s;
  logic [1:0]        sdi_s, ss_s;

  logic m_edge, m_lead, m_lvl;
  logic edge_sel, lead_sel, sdi_sel, ss_block, busy;
  logic wr_buf, rd_buf, wr_stat, load, coll_clr;
  logic sh_sdo, sh_active, done;
  logic [DATA_W-1:0] rx_byte;
  logic [ST_W-1:0]   stat;
  logic drive_sdo;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= '0;
      sdi_s <= '0;
      ss_s  <= '1;
    end else begin
      sck_s <= {sck_s[1:0], sck_in};
      sdi_s <= {sdi_s[0], sdi};
      ss_s  <= {ss_s[0], ss_n};
    end
  end

  spi_sck_gen #(.DIV_BASE_LOG2(DIV_BASE_LOG2)) u_gen (
    .clk(clk), .rst(rst), .run(run && !ctrl_q.slave),
    .idle_hi(ctrl_q.idle_hi), .div_sel(ctrl_q.div_sel),
    .edge_o(m_edge), .lead_o(m_lead), .sck_lvl_o(m_lvl)
  );

  always_comb begin
    edge_sel  = ctrl_q.slave ? (sck_s[1] ^ sck_s[2]) : m_edge;
    lead_sel  = ctrl_q.slave ? (sck_s[1] != ctrl_q.idle_hi) : m_lead;
    sdi_sel   = ctrl_q.slave ? sdi_s[1] : sdi;
    ss_block  = ctrl_q.slave && ctrl_q.ss_en && ss_s[1];
    busy      = ctrl_q.slave ? sh_active : run;
    wr_buf    = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
    rd_buf    = bus_sel && bus_rd && (bus_addr == ADDR_DATA);
    wr_stat   = bus_sel && bus_wr && (bus_addr == ADDR_STAT);
    coll_clr  = wr_stat && bus_wdata[ST_COLL];
    load      = wr_buf && !busy;
    drive_sdo = !ss_block;
    stat      = '0;
    stat[ST_FULL] = full;
    stat[ST_COLL] = coll;
    stat[ST_OVR]  = ovf;
    stat[ST_DONE] = irq_flag;
    stat[ST_BUSY] = busy;
  end

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .clear(ss_block),
    .edge_i(edge_sel), .lead_i(lead_sel),
    .out_on_lead(ctrl_q.out_on_lead),
    .sample_end(ctrl_q.sample_end && !ctrl_q.slave),
    .load(load), .load_data(bus_wdata), .sdi_i(sdi_sel),
    .sdo_o(sh_sdo), .active_o(sh_active), .done_o(done), .rx_o(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      buf_q     <= '0;
      full      <= 1'b0;
      coll      <= 1'b0;
      ovf       <= 1'b0;
      irq_flag  <= 1'b0;
      run       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_sel && bus_wr && (bus_addr == ADDR_CTRL)) ctrl_q <= ctrl_t'(bus_wdata[7:0]);

      if (load && !ctrl_q.slave) run <= 1'b1;
      else if (done)             run <= 1'b0;

      if (done) begin
        if (full && !rd_buf) ovf <= 1'b1;
        else begin
          buf_q <= rx_byte;
          full  <= 1'b1;
        end
      end else if (rd_buf) begin
        full <= 1'b0;
      end
      if (!done && wr_stat && bus_wdata[ST_OVR]) ovf <= 1'b0;

      if (done)                                irq_flag <= 1'b1;
      else if (wr_stat && bus_wdata[ST_DONE])  irq_flag <= 1'b0;

      if (wr_buf && busy) coll <= 1'b1;
      else if (coll_clr)  coll <= 1'b0;

      if (bus_sel && bus_rd) begin
        case (bus_addr)
          ADDR_DATA: bus_rdata <= buf_q;
          ADDR_CTRL: bus_rdata <= DATA_W'(ctrl_q);
          ADDR_STAT: bus_rdata <= DATA_W'(stat);
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_out <= 1'b0;
      sck_oe  <= 1'b0;
      sdo_out <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      if (ctrl_q.slave) begin
        sck_out <= 1'b0;
        sck_oe  <= 1'b0;
      end else if (ctrl_q.open_drain) begin
        sck_out <= 1'b0;
        sck_oe  <= !m_lvl;
      end else begin
        sck_out <= m_lvl;
        sck_oe  <= 1'b1;
      end
      if (ctrl_q.open_drain) begin
        sdo_out <= 1'b0;
        sdo_oe  <= drive_sdo && !sh_sdo;
      end else begin
        sdo_out <= sh_sdo;
        sdo_oe  <= drive_sdo;
      end
    end
  end

  assign irq = irq_flag;
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              full,
  input logic              rd_buf,
  input logic              wr_buf,
  input logic              busy,
  input logic              coll,
  input logic              coll_clr,
  input logic              ovf,
  input logic [DATA_W-1:0] buf_q,
  input logic              irq,
  input logic              ctrl_od,
  input logic              ctrl_slave,
  input logic              ss_block,
  input logic              sdo_oe,
  input logic              sdo_out,
  input logic              sck_oe,
  input logic              sck_out
);
  a_r2_done_fills: assert property (@(posedge clk) disable iff (rst)
    (done && !(full && !rd_buf)) |=> (full && irq));

  a_r3_read_empties: assert property (@(posedge clk) disable iff (rst)
    (rd_buf && !done) |=> !full);

  a_r4_coll_set: assert property (@(posedge clk) disable iff (rst)
    (wr_buf && busy) |=> coll);

  a_r4_coll_sticky: assert property (@(posedge clk) disable iff (rst)
    (coll && !coll_clr) |=> coll);

  a_r5_overrun_holds: assert property (@(posedge clk) disable iff (rst)
    (done && full && !rd_buf) |=> (ovf && $stable(buf_q)));

  a_r9_slave_no_sck: assert property (@(posedge clk) disable iff (rst)
    ctrl_slave |=> !sck_oe);

  a_r10_ss_release: assert property (@(posedge clk) disable iff (rst)
    ss_block |=> !sdo_oe);

  a_r11_od_low_only: assert property (@(posedge clk) disable iff (rst)
    ctrl_od |=> ((!sdo_oe || !sdo_out) && (!sck_oe || !sck_out)));
endmodule

bind spi_xfer_port spi_xfer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .done(done), .full(full), .rd_buf(rd_buf),
  .wr_buf(wr_buf), .busy(busy), .coll(coll), .coll_clr(coll_clr),
  .ovf(ovf), .buf_q(buf_q), .irq(irq), .ctrl_od(ctrl_q.open_drain),
  .ctrl_slave(ctrl_q.slave), .ss_block(ss_block), .sdo_oe(sdo_oe),
  .sdo_out(sdo_out), .sck_oe(sck_oe), .sck_out(sck_out)
);

// File: tb/test_spi_xfer_port.sv
module test_spi_xfer_port;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, sck_in = 0, sck_out, sck_oe, sdo_out, sdo_oe, ss_n = 1;
  logic lb_en = 1, tb_sdi = 0, sdi;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  wire sdo_eff = sdo_oe ? sdo_out : 1'b1;
  wire sck_eff = sck_oe ? sck_out : 1'b1;
  assign sdi = lb_en ? sdo_eff : tb_sdi;

  spi_xfer_port i_spi_xfer_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdo_out(sdo_out),
    .sdo_oe(sdo_oe), .sdi(sdi), .ss_n(ss_n)
  );

  // {ctrl, tx}: ctrl bit0 slave, 1 idle high, 2 data on leading, 3 end sample, 5:4 rate, 7 open drain
  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h063C, 16'h1C81,
                                      16'h2A5E, 16'h80C3, 16'h3A0F};

  int tog; logic sck_prev, mon_en = 0, msb_en = 0;
  logic [7:0] msb_sh;
  always @(negedge clk) if (mon_en) begin
    if (sck_eff != sck_prev) tog++;
    sck_prev = sck_eff;
  end
  always @(posedge sck_eff) if (msb_en) msb_sh = {msb_sh[6:0], sdo_eff};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_idle(output int polls);
    logic [7:0] s;
    polls = 0;
    do begin brd(2'd2, s); if (s[4]) polls++; end while (s[4]);
  endtask

  task automatic slave_bits(input logic [7:0] m, input int n, output logic [7:0] got);
    got = 0;
    for (int i = 0; i < n; i++) begin
      tb_sdi = m[7-i];
      repeat (8) @(negedge clk);
      sck_in = 1; got = {got[6:0], sdo_eff};
      repeat (8) @(negedge clk);
      sck_in = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, s, v2, got;
    int polls, half, d;
    int seen_keep = 0, seen_ovr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R7 reset state
    brd(2'd2, s); chk(s == 0, "R7 status after reset", s, 0);
    brd(2'd1, v); chk(v == 0, "R7 ctrl after reset", v, 0);
    chk(sck_out == 0 && irq == 0, "R7 idle low clock after reset", sck_out, 0);

    // table walk: master transfers with loopback (R1 R2 R6 R8 R11)
    for (int i = 0; i < 6; i++) begin
      logic [7:0] c, t;
      c = VEC[i][15:8]; t = VEC[i][7:0];
      half = 2 << (2 * ((c[5:4] == 3) ? 2 : c[5:4]));
      bwr(2'd1, c);
      repeat (3) @(negedge clk);
      chk(sck_eff == c[1], "R7 idle level", sck_eff, c[1]);
      tog = 0; sck_prev = sck_eff; mon_en = 1; msb_sh = 0; msb_en = (c[2:1] == 0);
      bwr(2'd0, t);
      wait_idle(polls);
      repeat (3) @(negedge clk);
      mon_en = 0; msb_en = 0;
      chk(polls >= 16*half - 1 && polls <= 16*half + 1, "R6 transfer length", polls, 16*half);
      chk(tog == 16, "R6 clock transitions", tog, 16);
      chk(sck_eff == c[1], "R6 clock back to idle", sck_eff, c[1]);
      brd(2'd2, s); chk(s[0] && s[3] && irq, "R2 full and done set", s, 8'h09);
      brd(2'd0, v); chk(v == t, "R1 R8 loopback byte", v, t);
      if (c[2:1] == 0) chk(msb_sh == t, "R1 msb first on wire", msb_sh, t);
      brd(2'd2, s); chk(!s[0], "R3 read clears full", s[0], 0);
      bwr(2'd2, 8'h0E);
    end

    // R11 open drain drives only low
    bwr(2'd1, 8'h80); bwr(2'd0, 8'h55);
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if ((sdo_oe && sdo_out) || (sck_oe && sck_out)) begin chk(0, "R11 drove high", 1, 0); break; end
    end
    chk(1, "R11 open drain sweep", 0, 0);
    wait_idle(polls); brd(2'd0, v); bwr(2'd2, 8'h0E);

    // R4 collision
    bwr(2'd1, 8'h20); bwr(2'd0, 8'hC6);
    repeat (10) @(negedge clk);
    bwr(2'd0, 8'h39);
    wait_idle(polls);
    brd(2'd0, v); chk(v == 8'hC6, "R4 colliding write discarded", v, 8'hC6);
    brd(2'd2, s); chk(s[1], "R4 collision set", s[1], 1);
    repeat (5) @(negedge clk);
    brd(2'd2, s); chk(s[1], "R4 collision sticky", s[1], 1);
    bwr(2'd2, 8'h02); brd(2'd2, s); chk(!s[1], "R4 collision cleared by W1C", s[1], 0);

    // R5 overrun in master mode
    bwr(2'd1, 8'h00); bwr(2'd0, 8'h6A); wait_idle(polls);
    bwr(2'd0, 8'h17); wait_idle(polls);
    brd(2'd2, s); chk(s[2] && s[0], "R5 overrun and full", s, 8'h05);
    brd(2'd0, v); chk(v == 8'h6A, "R5 buffer kept first byte", v, 8'h6A);
    bwr(2'd2, 8'h0E); brd(2'd2, s); chk(!s[2], "R4 overrun W1C", s[2], 0);

    // R9 slave transfer driven by bench clock
    lb_en = 0;
    bwr(2'd1, 8'h01); bwr(2'd0, 8'h96);
    repeat (3) @(negedge clk);
    chk(sck_oe == 0, "R9 slave sck released", sck_oe, 0);
    slave_bits(8'h4B, 8, got);
    repeat (10) @(negedge clk);
    chk(got == 8'h96, "R9 R1 slave sends msb first", got, 8'h96);
    brd(2'd0, v); chk(v == 8'h4B, "R9 slave receive", v, 8'h4B);

    // R10 slave select
    bwr(2'd1, 8'h41); ss_n = 1;
    repeat (5) @(negedge clk);
    chk(sdo_oe == 0, "R10 sdo released when deselected", sdo_oe, 0);
    ss_n = 0; repeat (5) @(negedge clk);
    chk(sdo_oe == 1, "R10 sdo driven when selected", sdo_oe, 1);
    slave_bits(8'hFF, 3, got);
    ss_n = 1; repeat (5) @(negedge clk); ss_n = 0; repeat (5) @(negedge clk);
    slave_bits(8'h5A, 8, got);
    repeat (10) @(negedge clk);
    brd(2'd0, v); chk(v == 8'h5A, "R10 count restarted by select", v, 8'h5A);
    brd(2'd2, s); chk(!s[2], "R10 no overrun", s[2], 0);
    ss_n = 1;

    // R3 R5 same-cycle sweep: buffer read against completion
    bwr(2'd1, 8'h01);
    for (d = 0; d < 7; d++) begin
      brd(2'd0, v); bwr(2'd2, 8'h0E);
      slave_bits(8'h11, 8, got);
      repeat (12) @(negedge clk);
      slave_bits(8'h22, 8, got);
      repeat (d) @(negedge clk);
      brd(2'd0, v);
      repeat (10) @(negedge clk);
      brd(2'd2, s); brd(2'd0, v2);
      chk(v == 8'h11, "R3 read returns older byte", v, 8'h11);
      if (s[2]) begin
        seen_ovr++;
        chk(!s[0] && v2 == 8'h11, "R5 late read overrun", {s, v2}, 16'h0411);
      end else begin
        seen_keep++;
        chk(s[0] && v2 == 8'h22, "R3 early or same-cycle read keeps new", {s, v2}, 16'h0122);
      end
      if (d == 0) chk(!s[2], "R3 early read no overrun", s[2], 0);
      if (d == 6) chk(s[2], "R5 late read overrun", s[2], 1);
    end
    chk(seen_keep > 0 && seen_ovr > 0, "R3 R5 both outcomes", seen_keep, seen_ovr);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule